// File: doc/BRIEF.md
# Redundant Clock Failover Controller

This block supervises two candidate clocks and decides which of them may pass into a downstream clock path. A free-running reference clock, faster than either candidate, samples both candidates through synchronizers. It counts reference cycles since the last level change seen on each one. A candidate that holds its level for a programmed number of reference cycles is declared failed, and its failure flag stays raised until software-visible alarm clearing or a master reset.

A select pin names the primary candidate. The controller starts on that candidate and keeps watching both. It moves to the other candidate only when the one in use has failed and the other one is still healthy. A failure of the idle candidate only raises that candidate's flag. A manual override pin turns automatic switching off; while it is high, the selection follows the select pin. The controller changes the two mux enables in a fixed order, so the downstream mux never passes a clipped pulse: the old enable falls first, then the new enable rises on a falling edge of the new clock.

All control pins and outputs are plain signals, synchronous to the reference clock. There is no streaming data interface, so no valid/ready rules apply.

Top module: `clk_failover`

## Requirements
- R1: While `rst` is high at a reference clock edge, both failure flags clear, `gate_en` clears to 2'b00, and `sel_out` takes the value of `prim_sel`.
- R2: Bit i of `bad_flag` (bit 0 for `clk_in[0]`, bit 1 for `clk_in[1]`) sets once `clk_in[i]` has held one level for `period_lim` reference cycles. It stays clear while the input keeps toggling with half-periods well below that limit. Both inputs are watched whichever one is selected.
- R3: A set failure flag stays set, even after its clock toggles again, until `alarm_clr` or `rst`.
- R4: `alarm_clr` clears both flags on the next edge. A flag whose input is still stuck sets again in the cycle after `alarm_clr` falls.
- R5: A failure of the input not named by `sel_out` only raises its flag; `sel_out` and `gate_en` are unchanged.
- R6: Outside override, when the selected input's flag is set and the other input's flag is clear, `sel_out` moves to the other input.
- R7: Outside override, while both flags are set, `sel_out` holds its value.
- R8: `gate_en` has at most one bit high (bit i enables `clk_in[i]`). A bit falls only on a synchronized falling edge of its clock, or at once if that clock is flagged bad. The new bit rises only after both bits are low, on a synchronized falling edge of its clock.
- R9: While `manual_ovr` is high, `sel_out` follows `prim_sel` one cycle later, whatever the flags show.
- R10: Outside override and reset, changes on `prim_sel` have no effect on `sel_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock, faster than both candidates |
| rst | input | 1 | Synchronous master reset, active high |
| clk_in | input | 2 | The two candidate clocks, asynchronous to `ref_clk` |
| prim_sel | input | 1 | Names the primary candidate (0 or 1) |
| manual_ovr | input | 1 | High: selection follows `prim_sel`, no automatic switching |
| alarm_clr | input | 1 | High: clear both failure flags |
| period_lim | input | CNT_W | Stuck limit in reference cycles, about one nominal input period, at least 1 |
| bad_flag | output | 2 | Sticky per-input failure flags |
| sel_out | output | 1 | Candidate currently in use |
| gate_en | output | 2 | Glitch-free mux enables, one per candidate |

## Verification
The hardest state to reach is two flags set at once, followed by an alarm clear while one input has recovered and the other is still stuck. This has to show that the still-stuck flag sets again one cycle later and that the controller then switches away from the in-use, still-dead clock. The bench reaches it by halting the bench clock generators one after another, restarting only one, and pulsing the clear pin. A monitor running at every reference cycle checks the enable pair for overlap during each switch.

// File: rtl/clkfo_pkg.sv
package clkfo_pkg;
  localparam int unsigned NUM_SRC = 2;
  typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/clkfo_sync.sv
module clkfo_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic ref_clk,
  input  logic rst,
  input  logic din,
  output logic tgl,
  output logic fall
);
  localparam int unsigned LAST = STAGES;
  logic [LAST:0] pipe;

  always_ff @(posedge ref_clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[LAST-1:0], din};
  end

  // pipe[LAST-1] is the synchronized level, pipe[LAST] its previous value
  assign tgl  = pipe[LAST] ^ pipe[LAST-1];
  assign fall = pipe[LAST] & ~pipe[LAST-1];
endmodule

// File: rtl/clkfo_stuck.sv
module clkfo_stuck #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             ref_clk,
  input  logic             rst,
  input  logic             tgl,
  input  logic             clr,
  input  logic [CNT_W-1:0] lim,
  output logic             bad
);
  logic [CNT_W-1:0] idle_cnt;
  logic             stuck;

  always_ff @(posedge ref_clk) begin
    if (rst || tgl)          idle_cnt <= '0;
    else if (idle_cnt < lim) idle_cnt <= idle_cnt + 1'b1;
  end

  assign stuck = (idle_cnt >= lim);

  always_ff @(posedge ref_clk) begin
    if (rst)        bad <= 1'b0;
    else if (clr)   bad <= 1'b0;
    else if (stuck) bad <= 1'b1;
  end

  // R3
  flag_sticky_chk: assert property (@(posedge ref_clk) disable iff (rst)
    (bad && !clr) |=> bad);

  // R4
  flag_clear_chk: assert property (@(posedge ref_clk) disable iff (rst)
    clr |=> !bad);
endmodule

// File: rtl/clkfo_select.sv
module clkfo_select
  import clkfo_pkg::*;
(
  input  logic     ref_clk,
  input  logic     rst,
  input  logic     prim_sel,
  input  logic     manual_ovr,
  input  src_vec_t bad,
  output logic     sel
);
  logic alt;
  assign alt = ~sel;

  always_ff @(posedge ref_clk) begin
    if (rst || manual_ovr)            sel <= prim_sel;
    else if (bad[sel] && !bad[alt])   sel <= alt;
  end

  // R5
  hold_healthy_chk: assert property (@(posedge ref_clk) disable iff (rst)
    (!manual_ovr && !bad[sel]) |=> $stable(sel));

  // R7
  hold_both_bad_chk: assert property (@(posedge ref_clk) disable iff (rst)
    (!manual_ovr && (&bad)) |=> $stable(sel));

  // R6
  switch_away_chk: assert property (@(posedge ref_clk) disable iff (rst)
    (!manual_ovr && bad[sel] && !bad[alt]) |=> (sel != $past(sel)));

  // R9
  manual_follow_chk: assert property (@(posedge ref_clk) disable iff (rst)
    manual_ovr |=> (sel == $past(prim_sel)));
endmodule

// File: rtl/clkfo_gate.sv
module clkfo_gate
  import clkfo_pkg::*;
(
  input  logic     ref_clk,
  input  logic     rst,
  input  logic     sel,
  input  src_vec_t fall,
  input  src_vec_t bad,
  output src_vec_t en
);
  logic     alt;
  src_vec_t en_nxt;

  assign alt = ~sel;

  always_comb begin
    en_nxt = en;
    if (en[alt]) begin
      if (fall[alt] || bad[alt]) en_nxt[alt] = 1'b0;
    end else if (!en[sel] && fall[sel]) begin
      en_nxt[sel] = 1'b1;
    end
  end

  always_ff @(posedge ref_clk) begin
    if (rst) en <= '0;
    else     en <= en_nxt;
  end

  // R8
  no_overlap_chk: assert property (@(posedge ref_clk) disable iff (rst)
    $onehot0(en));

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
    // R8
    rise_on_fall_chk: assert property (@(posedge ref_clk) disable iff (rst)
      $rose(en[i]) |-> ($past(fall[i]) && !$past(en[1-i])));
    // R8
    drop_on_fall_chk: assert property (@(posedge ref_clk) disable iff (rst)
      $fell(en[i]) |-> ($past(fall[i]) || $past(bad[i])));
  end
endmodule

// File: rtl/clk_failover.sv
module clk_failover
  import clkfo_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             ref_clk,
  input  logic             rst,
  input  logic [1:0]       clk_in,
  input  logic             prim_sel,
  input  logic             manual_ovr,
  input  logic             alarm_clr,
  input  logic [CNT_W-1:0] period_lim,
  output logic [1:0]       bad_flag,
  output logic             sel_out,
  output logic [1:0]       gate_en
);
  src_vec_t tgl, fall, bad;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    clkfo_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .ref_clk (ref_clk),
      .rst     (rst),
      .din     (clk_in[i]),
      .tgl     (tgl[i]),
      .fall    (fall[i])
    );
    clkfo_stuck #(.CNT_W(CNT_W)) u_stuck (
      .ref_clk (ref_clk),
      .rst     (rst),
      .tgl     (tgl[i]),
      .clr     (alarm_clr),
      .lim     (period_lim),
      .bad     (bad[i])
    );
  end

  clkfo_select u_select (
    .ref_clk    (ref_clk),
    .rst        (rst),
    .prim_sel   (prim_sel),
    .manual_ovr (manual_ovr),
    .bad        (bad),
    .sel        (sel_out)
  );

  clkfo_gate u_gate (
    .ref_clk (ref_clk),
    .rst     (rst),
    .sel     (sel_out),
    .fall    (fall),
    .bad     (bad),
    .en      (gate_en)
  );

  assign bad_flag = bad;

  // R10
  ignore_prim_chk: assert property (@(posedge ref_clk) disable iff (rst)
    (!manual_ovr && !bad_flag[sel_out]) |=> $stable(sel_out));
endmodule

// File: tb/test_clk_failover.sv
module test_clk_failover;
  localparam int CNT_W = 16;

  logic             ref_clk = 1'b0;
  logic             rst = 1'b1;
  logic [1:0]       clk_in = 2'b00;
  logic             prim_sel = 1'b0;
  logic             manual_ovr = 1'b0;
  logic             alarm_clr = 1'b0;
  logic [CNT_W-1:0] period_lim = 16'd12;
  logic [1:0]       bad_flag;
  logic             sel_out;
  logic [1:0]       gate_en;

  logic run0 = 1'b1;
  logic run1 = 1'b1;
  int   checks = 0;
  int   errors = 0;
  int   overlap = 0;
  logic done = 1'b0;

  clk_failover #(.CNT_W(CNT_W)) i_clk_failover (
    .ref_clk(ref_clk), .rst(rst), .clk_in(clk_in), .prim_sel(prim_sel),
    .manual_ovr(manual_ovr), .alarm_clr(alarm_clr), .period_lim(period_lim),
    .bad_flag(bad_flag), .sel_out(sel_out), .gate_en(gate_en)
  );

  always #4 ref_clk = ~ref_clk;
  always #40 if (run0) clk_in[0] = ~clk_in[0];
  always #48 if (run1) clk_in[1] = ~clk_in[1];

  always @(negedge ref_clk) if (!rst && gate_en == 2'b11) overlap++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic pulse_clr(input int n);
    alarm_clr = 1'b1;
    cyc(n);
    alarm_clr = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1; prim_sel = 1'b0;
    cyc(4);
    chk("R1 bad", bad_flag, 0);
    chk("R1 sel", sel_out, 0);
    chk("R1 en", gate_en, 0);
    rst = 1'b0;
    cyc(40);
    chk("R2 no false flag", bad_flag, 0);
    chk("R8 start en", gate_en, 1);
  endtask

  task automatic t_idle_fail;
    run1 = 1'b0;
    cyc(6);
    chk("R2 not early", bad_flag, 0);
    cyc(30);
    chk("R2 idle flagged", bad_flag, 2);
    chk("R5 sel kept", sel_out, 0);
    chk("R5 en kept", gate_en, 1);
  endtask

  task automatic t_sticky;
    run1 = 1'b1;
    cyc(40);
    chk("R3 sticky", bad_flag, 2);
    pulse_clr(1);
    cyc(20);
    chk("R4 cleared", bad_flag, 0);
  endtask

  task automatic t_prim_fail;
    run0 = 1'b0;
    cyc(60);
    chk("R6 flag", bad_flag, 1);
    chk("R6 switched", sel_out, 1);
    chk("R8 new en", gate_en, 2);
  endtask

  task automatic t_reflag;
    pulse_clr(2);
    chk("R4 clear while stuck", bad_flag[0], 0);
    cyc(3);
    chk("R4 reflag", bad_flag[0], 1);
    chk("R5 sel", sel_out, 1);
  endtask

  task automatic t_both_bad;
    run1 = 1'b0;
    cyc(60);
    chk("R7 flags", bad_flag, 3);
    chk("R7 sel hold", sel_out, 1);
  endtask

  task automatic t_recover;
    run0 = 1'b1;
    cyc(20);
    pulse_clr(1);
    cyc(60);
    chk("R4 one reflags", bad_flag, 2);
    chk("R6 back to 0", sel_out, 0);
    chk("R8 en moved", gate_en, 1);
  endtask

  task automatic t_manual;
    run1 = 1'b1;
    cyc(20);
    pulse_clr(1);
    manual_ovr = 1'b1; prim_sel = 1'b1;
    cyc(2);
    chk("R9 follow 1", sel_out, 1);
    cyc(60);
    chk("R9 en", gate_en, 2);
    prim_sel = 1'b0;
    cyc(2);
    chk("R9 follow 0", sel_out, 0);
    manual_ovr = 1'b0;
    cyc(2);
    prim_sel = 1'b1;
    cyc(20);
    chk("R10 ignored", sel_out, 0);
  endtask

  task automatic t_master;
    run0 = 1'b0;
    cyc(40);
    rst = 1'b1;
    cyc(2);
    chk("R1 reset sel", sel_out, 1);
    chk("R1 reset flags", bad_flag, 0);
    rst = 1'b0;
    run0 = 1'b1;
    cyc(20);
  endtask

  initial begin
    t_reset();
    t_idle_fail();
    t_sticky();
    t_prim_fail();
    t_reflag();
    t_both_bad();
    t_recover();
    t_manual();
    t_master();
    chk("R8 no overlap", overlap, 0);
    done = 1'b1;
  end

  initial begin
    for (int k = 0; k < 100000 && !done; k++) @(posedge ref_clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule